// File: doc/BRIEF.md
# I2C Start/Stop Condition Detector

This block watches the clock and data lines of an I2C bus and tells apart genuine START and STOP conditions from glitches or misplaced data edges. A falling data edge while the clock is high is taken as a START, and a rising data edge while the clock is high is taken as a STOP. Either one counts only when three timing windows are all met. The clock must have been high long enough before the edge (release window). The data line must have held its old level long enough before the edge (setup window). The clock must stay high and the data line must keep its new level long enough after the edge (hold window).

Each accepted condition gives a one-cycle pulse. After a further programmed delay, a bus-busy flag is set by a START or cleared by a STOP. A STOP seen while the device is not bus master also gives an interrupt-request pulse. All windows come from one 5-bit timing value in standard mode; high-speed mode uses fixed short windows. Half-cycle window lengths are rounded up to whole clock cycles. A timing value that is zero or odd is replaced by the next even value, and a configuration-error flag reports it.

Top module: `i2c_cond_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it is released, `bus_busy`, `start_seen`, `stop_seen`, `stop_irq` and `cfg_err` are all 0.
- R2: A START is a fall of `sda_in` while `scl_in` is high. Both pins pass through a two-stage synchronizer. A START that meets all windows gives a one-cycle `start_seen` pulse, and `bus_busy` is later set to 1.
- R3: A STOP is a rise of `sda_in` while `scl_in` is high. A STOP that meets all windows gives a one-cycle `stop_seen` pulse, and `bus_busy` is later cleared to 0. `start_seen` and `stop_seen` are never high together.
- R4: In standard mode, with effective timing value E, the clock must have been high for at least E+1 cycles before the data edge. With fewer cycles, the edge is ignored.
- R5: In standard mode, the data line must have held its previous level for at least E/2+1 cycles before the edge, which is (E+1)/2 rounded up. Otherwise the edge is ignored.
- R6: In standard mode, the clock must stay high and the data line must keep its new level for E/2+1 cycles, counting the edge cycle. If the clock falls or the data line reverts earlier, the condition is dropped.
- R7: In standard mode, `bus_busy` changes E/2+2 cycles after the detection pulse, which is (E-1)/2+2 rounded up.
- R8: With `fast_mode` = 1, the windows are fixed: release 4 cycles, setup 2, hold 2, and busy delay 4.
- R9: `stop_irq` pulses together with `stop_seen` only if `master_mode` was 0 when the STOP completed. With `master_mode` = 1, it stays 0.
- R10: A `timing_val` of 0 is used as 2, and an odd value v is used as v+1. While enabled with such a value, `cfg_err` is 1 from the next cycle on.
- R11: While `enable` is 0, no condition is recognised, no pulse is given, `bus_busy` is held at 0 and `cfg_err` is 0.
- R12: A condition accepted while an earlier busy update is still pending replaces that update, and its delay starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Turns detection on |
| fast_mode | input | 1 | 1 selects the fixed high-speed windows |
| master_mode | input | 1 | 1 when the device is bus master |
| timing_val | input | TV_W (5) | Condition timing value for standard mode |
| scl_in | input | 1 | Asynchronous clock line |
| sda_in | input | 1 | Asynchronous data line |
| bus_busy | output | 1 | Bus-busy flag |
| start_seen | output | 1 | One-cycle pulse for an accepted START |
| stop_seen | output | 1 | One-cycle pulse for an accepted STOP |
| stop_irq | output | 1 | One-cycle STOP interrupt pulse in slave mode |
| cfg_err | output | 1 | Illegal timing value in use |

## Verification
The assertions assume that `timing_val` and `fast_mode` stay steady while a condition is being qualified. They also assume that line levels are held for whole clock cycles, so that no edge is lost in the synchronizer. The stimulus changes the configuration only while the bus is idle between sequences. It drives both lines on the inactive clock edge and holds each level for a counted number of cycles. This places every release, setup and hold length exactly at the chosen boundary or one cycle short of it.

// File: rtl/i2c_cond_pkg.sv
// Shared types for the I2C start/stop condition detector.
// Assumes: window counts never exceed 2**WIN_W - 1.
package i2c_cond_pkg;
    localparam int unsigned WIN_W = 7;

    typedef enum logic [0:0] {
        KIND_START = 1'b0,
        KIND_STOP  = 1'b1
    } cond_kind_e;

    typedef enum logic [0:0] {
        QS_IDLE = 1'b0,
        QS_HOLD = 1'b1
    } qual_state_e;

    typedef struct packed {
        logic [WIN_W-1:0] rel;
        logic [WIN_W-1:0] setup;
        logic [WIN_W-1:0] hold;
        logic [WIN_W-1:0] dly;
    } win_t;
endpackage

// File: rtl/i2c_cond_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit lines.
// Assumes: each line is held for at least one clock cycle; the reset value
// is the idle bus level.
module i2c_cond_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= {WIDTH{RST_VAL}};
                    else        stage_q[g] <= d;
                end
            end else begin : g_next
                // Later stages shift the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= {WIDTH{RST_VAL}};
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_timing.sv
// Turns the timing value and the mode select into window lengths in whole
// cycles, and registers the configuration-error flag.
// Assumes: inputs are steady while a condition is being qualified.
module i2c_cond_timing
    import i2c_cond_pkg::*;
#(
    parameter int unsigned TV_W       = 5,
    parameter int unsigned FAST_REL   = 4,
    parameter int unsigned FAST_SETUP = 2,
    parameter int unsigned FAST_HOLD  = 2,
    parameter int unsigned FAST_DLY   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            fast_mode,
    input  logic [TV_W-1:0] timing_val,
    output win_t            win,
    output logic            cfg_err
);
    localparam int unsigned EFF_W = TV_W + 1;

    logic             illegal;
    logic [EFF_W-1:0] eff;
    logic [WIN_W-1:0] eff_w;
    logic [WIN_W-1:0] half_w;

    // Clamp zero or odd values up to the next even value.
    always_comb begin
        illegal = (timing_val == '0) || timing_val[0];
        if (timing_val == '0) eff = EFF_W'(2);
        else                  eff = EFF_W'(timing_val) + EFF_W'(timing_val[0]);
        eff_w  = WIN_W'(eff);
        half_w = eff_w >> 1;
    end

    // Pick the window set for the selected mode, rounding half cycles up.
    always_comb begin
        if (fast_mode) begin
            win.rel   = WIN_W'(FAST_REL);
            win.setup = WIN_W'(FAST_SETUP);
            win.hold  = WIN_W'(FAST_HOLD);
            win.dly   = WIN_W'(FAST_DLY);
        end else begin
            win.rel   = eff_w + WIN_W'(1);
            win.setup = half_w + WIN_W'(1);
            win.hold  = half_w + WIN_W'(1);
            win.dly   = half_w + WIN_W'(2);
        end
    end

    // Register the error flag while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= enable && illegal;
    end

    assert_err_follows_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && timing_val[0]) |=> cfg_err)
        else $error("odd timing value did not raise cfg_err");
endmodule

// File: rtl/i2c_cond_qualify.sv
// Measures clock-high and data-stable run lengths, spots data edges while the
// clock is high, and qualifies them against release, setup and hold windows.
// det_valid is a combinational strobe for the last hold cycle.
// Assumes: inputs are already synchronized; every window is at least 2.
module i2c_cond_qualify
    import i2c_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       scl_s,
    input  logic       sda_s,
    input  win_t       win,
    output logic       det_valid,
    output cond_kind_e det_kind
);
    localparam logic [WIN_W-1:0] SAT = '1;

    logic [WIN_W-1:0] scl_run_q;
    logic [WIN_W-1:0] sda_run_q;
    logic [WIN_W-1:0] hold_cnt_q;
    logic             sda_d_q;
    qual_state_e      state_q;
    cond_kind_e       kind_q;
    logic             sda_edge;
    logic             cand;
    logic             hold_ok;

    // Edge, candidate and hold checks for the current cycle.
    always_comb begin
        sda_edge  = sda_s ^ sda_d_q;
        cand      = enable && sda_edge && scl_s &&
                    (scl_run_q >= win.rel) && (sda_run_q >= win.setup);
        hold_ok   = scl_s && (sda_s == (kind_q == KIND_STOP));
        det_valid = enable && (state_q == QS_HOLD) && hold_ok &&
                    (hold_cnt_q == win.hold - WIN_W'(1));
        det_kind  = kind_q;
    end

    // Saturating run lengths of clock-high and of a steady data level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_run_q <= '0;
            sda_run_q <= '0;
            sda_d_q   <= 1'b1;
        end else begin
            sda_d_q <= sda_s;
            if (!scl_s)                scl_run_q <= '0;
            else if (scl_run_q != SAT) scl_run_q <= scl_run_q + WIN_W'(1);
            if (sda_edge)              sda_run_q <= WIN_W'(1);
            else if (sda_run_q != SAT) sda_run_q <= sda_run_q + WIN_W'(1);
        end
    end

    // Hold-window tracker: start on a candidate, drop on a violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= QS_IDLE;
            kind_q     <= KIND_START;
            hold_cnt_q <= '0;
        end else if (!enable) begin
            state_q    <= QS_IDLE;
        end else begin
            case (state_q)
                QS_IDLE: if (cand) begin
                    state_q    <= QS_HOLD;
                    hold_cnt_q <= WIN_W'(1);
                    kind_q     <= sda_s ? KIND_STOP : KIND_START;
                end
                QS_HOLD: begin
                    if (!hold_ok || det_valid) state_q <= QS_IDLE;
                    else                       hold_cnt_q <= hold_cnt_q + WIN_W'(1);
                end
                default: state_q <= QS_IDLE;
            endcase
        end
    end

    assert_start_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && det_kind == KIND_START) |-> (!sda_s && scl_s))
        else $error("START accepted with wrong line levels");

    assert_hold_drop_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_HOLD && !scl_s) |=> (state_q == QS_IDLE))
        else $error("hold window survived a clock fall");

    assert_release_met_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_IDLE && enable && sda_edge && scl_s && scl_run_q < win.rel) |=> (state_q == QS_IDLE))
        else $error("edge accepted before release time");
endmodule

// File: rtl/i2c_cond_busy.sv
// Turns detection strobes into output pulses. Applies the delayed busy-flag
// update, where a newer condition replaces a pending one.
// Assumes: dly >= 1; det_valid is a single-cycle strobe.
module i2c_cond_busy
    import i2c_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             master_mode,
    input  logic             det_valid,
    input  cond_kind_e       det_kind,
    input  logic [WIN_W-1:0] dly,
    output logic             bus_busy,
    output logic             start_seen,
    output logic             stop_seen,
    output logic             stop_irq
);
    logic             pend_q;
    cond_kind_e       pend_kind_q;
    logic [WIN_W-1:0] pend_cnt_q;

    // One-cycle pulses registered from the detection strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            stop_irq   <= 1'b0;
        end else begin
            start_seen <= det_valid && (det_kind == KIND_START);
            stop_seen  <= det_valid && (det_kind == KIND_STOP);
            stop_irq   <= det_valid && (det_kind == KIND_STOP) && !master_mode;
        end
    end

    // Delayed busy update; a new detection reloads the delay.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pend_q      <= 1'b0;
            pend_kind_q <= KIND_START;
            pend_cnt_q  <= '0;
            bus_busy    <= 1'b0;
        end else if (det_valid) begin
            pend_q      <= 1'b1;
            pend_kind_q <= det_kind;
            pend_cnt_q  <= dly;
        end else if (pend_q) begin
            if (pend_cnt_q == WIN_W'(1)) begin
                bus_busy <= (pend_kind_q == KIND_START);
                pend_q   <= 1'b0;
            end else begin
                pend_cnt_q <= pend_cnt_q - WIN_W'(1);
            end
        end
    end

    assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_seen, stop_seen}))
        else $error("START and STOP pulses together");

    assert_irq_slave_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> (stop_seen && !$past(master_mode)))
        else $error("stop_irq without slave STOP");

    assert_busy_rise_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> ($past(pend_q) && $past(pend_kind_q) == KIND_START))
        else $error("busy set without a pending START");

    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bus_busy && !start_seen && !stop_seen && !stop_irq))
        else $error("activity while disabled");
endmodule

// File: rtl/i2c_cond_monitor.sv
// Top level of the I2C start/stop condition detector. It synchronizes the bus
// lines, derives the timing windows, qualifies conditions, and drives the
// pulses and the busy flag.
// Assumes: configuration inputs change only while the bus is idle.
module i2c_cond_monitor
    import i2c_cond_pkg::*;
#(
    parameter int unsigned TV_W        = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            fast_mode,
    input  logic            master_mode,
    input  logic [TV_W-1:0] timing_val,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            bus_busy,
    output logic            start_seen,
    output logic            stop_seen,
    output logic            stop_irq,
    output logic            cfg_err
);
    logic [1:0] lines_s;
    win_t       win;
    logic       det_valid;
    cond_kind_e det_kind;

    i2c_cond_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_in, sda_in}),
        .q    (lines_s)
    );

    i2c_cond_timing #(
        .TV_W(TV_W)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .fast_mode (fast_mode),
        .timing_val(timing_val),
        .win       (win),
        .cfg_err   (cfg_err)
    );

    i2c_cond_qualify u_qualify (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .win      (win),
        .det_valid(det_valid),
        .det_kind (det_kind)
    );

    i2c_cond_busy u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .master_mode(master_mode),
        .det_valid  (det_valid),
        .det_kind   (det_kind),
        .dly        (win.dly),
        .bus_busy   (bus_busy),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .stop_irq   (stop_irq)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!bus_busy && !start_seen && !stop_seen && !stop_irq && !cfg_err))
        else $error("outputs not cleared by reset");
endmodule

// File: tb/i2c_cond_monitor_tb.sv
// Bench for i2c_cond_monitor. A behavioural cycle model predicts every output
// on every clock. Per-scenario event counts, delays and final flag levels are
// checked against values worked out by hand from the requirements.
module i2c_cond_monitor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       fast_mode = 1'b0;
    logic       master_mode = 1'b0;
    logic [4:0] timing_val = 5'd8;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       bus_busy, start_seen, stop_seen, stop_irq, cfg_err;

    int    vecs = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    i2c_cond_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
        .master_mode(master_mode), .timing_val(timing_val),
        .scl_in(scl_in), .sda_in(sda_in), .bus_busy(bus_busy),
        .start_seen(start_seen), .stop_seen(stop_seen),
        .stop_irq(stop_irq), .cfg_err(cfg_err)
    );

    // Reference model state
    int m_c0, m_c1, m_d0, m_d1, m_dprev;
    int sclrun, sdarun, hold_on, hold_n, hold_stop;
    int pend, pend_cnt, pend_stop;
    int e_busy, e_st, e_sp, e_irq, e_err;
    int tv, ve, rel, setv, holdv, dlyv, det, det_stop, edge_now;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c0 = 1; m_c1 = 1; m_d0 = 1; m_d1 = 1; m_dprev = 1;
            sclrun = 0; sdarun = 0; hold_on = 0; hold_n = 0; hold_stop = 0;
            pend = 0; pend_cnt = 0; pend_stop = 0;
            e_busy = 0; e_st = 0; e_sp = 0; e_irq = 0; e_err = 0;
        end else begin
            tv = int'(timing_val);
            ve = (tv == 0) ? 2 : ((tv % 2 == 1) ? tv + 1 : tv);
            if (fast_mode) begin
                rel = 4; setv = 2; holdv = 2; dlyv = 4;
            end else begin
                rel = ve + 1; setv = (ve + 2) / 2; holdv = setv; dlyv = (ve + 4) / 2;
            end
            edge_now = (m_d1 != m_dprev);
            det = 0; det_stop = 0;
            if (!enable) hold_on = 0;
            else if (hold_on != 0) begin
                if (m_c1 == 0 || m_d1 != hold_stop) hold_on = 0;
                else if (hold_n == holdv - 1) begin
                    det = 1; det_stop = hold_stop; hold_on = 0;
                end else hold_n++;
            end else if (edge_now && m_c1 == 1 && sclrun >= rel && sdarun >= setv) begin
                hold_on = 1; hold_n = 1; hold_stop = m_d1;
            end
            e_st  = (enable && det && !det_stop) ? 1 : 0;
            e_sp  = (enable && det && det_stop) ? 1 : 0;
            e_irq = (enable && det && det_stop && !master_mode) ? 1 : 0;
            if (!enable) begin
                pend = 0; e_busy = 0;
            end else if (det) begin
                pend = 1; pend_cnt = dlyv; pend_stop = det_stop;
            end else if (pend) begin
                if (pend_cnt == 1) begin
                    e_busy = pend_stop ? 0 : 1; pend = 0;
                end else pend_cnt--;
            end
            e_err = (enable && (tv == 0 || tv % 2 == 1)) ? 1 : 0;
            sclrun = m_c1 ? ((sclrun < 127) ? sclrun + 1 : 127) : 0;
            sdarun = edge_now ? 1 : ((sdarun < 127) ? sdarun + 1 : 127);
            m_dprev = m_d1;
            m_c1 = m_c0; m_d1 = m_d0;
            m_c0 = scl_in; m_d0 = sda_in;
        end
    end

    // Scenario monitors
    int n_st, n_sp, n_irq, busy_fell, lat, t_st, cyc;
    logic busy_prev = 1'b0;

    task automatic cmp1(string sig, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, sig, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            vecs++;
            cmp1("bus_busy", int'(bus_busy), e_busy);
            cmp1("start_seen", int'(start_seen), e_st);
            cmp1("stop_seen", int'(stop_seen), e_sp);
            cmp1("stop_irq", int'(stop_irq), e_irq);
            cmp1("cfg_err", int'(cfg_err), e_err);
            if (start_seen) begin n_st++; t_st = cyc; end
            if (stop_seen) n_sp++;
            if (stop_irq) n_irq++;
            if (bus_busy && !busy_prev) lat = cyc - t_st;
            if (!bus_busy && busy_prev) busy_fell++;
        end
        busy_prev = bus_busy;
    end

    task automatic chk(string tag, string what, int act, int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        n_st = 0; n_sp = 0; n_irq = 0; busy_fell = 0; lat = -1;
    endtask

    task automatic drv(input logic c, input logic d, input int n);
        scl_in = c; sda_in = d;
        repeat (n) @(negedge clk);
    endtask

    // START with k clock-high cycles before the fall and h hold cycles.
    task automatic start_seq(input int k, input int h);
        drv(1'b0, 1'b1, 4); drv(1'b1, 1'b1, k); drv(1'b1, 1'b0, h); drv(1'b0, 1'b0, 12);
    endtask

    // STOP with k clock-high cycles before the rise; the bus then stays idle.
    task automatic stop_seq(input int k);
        drv(1'b0, 1'b0, 4); drv(1'b1, 1'b0, k); drv(1'b1, 1'b1, 20);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R1: outputs idle during reset and just after release
        cur_req = "R1";
        chk("R1", "bus_busy in reset", int'(bus_busy), 0);
        chk("R1", "cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        drv(1'b1, 1'b1, 3);
        chk("R1", "start_seen after reset", int'(start_seen), 0);
        chk("R1", "bus_busy after reset", int'(bus_busy), 0);
        drv(1'b1, 1'b1, 20);

        // R2 / R7: START with E=8, busy delay 6
        cur_req = "R2"; clr();
        start_seq(12, 8);
        chk("R2", "start pulses", n_st, 1);
        chk("R2", "busy after START", int'(bus_busy), 1);
        chk("R7", "busy delay std", lat, 6);

        // R3: STOP clears busy, slave interrupt
        cur_req = "R3"; clr();
        stop_seq(12);
        chk("R3", "stop pulses", n_sp, 1);
        chk("R3", "busy after STOP", int'(bus_busy), 0);
        chk("R9", "irq in slave mode", n_irq, 1);

        // R9: master mode suppresses interrupt
        cur_req = "R9"; clr(); master_mode = 1'b1;
        start_seq(12, 8);
        stop_seq(12);
        chk("R9", "stop pulses master", n_sp, 1);
        chk("R9", "irq in master mode", n_irq, 0);
        master_mode = 1'b0;

        // R4: release boundary at E+1 = 9
        cur_req = "R4"; clr();
        start_seq(8, 8);
        chk("R4", "start with release 8", n_st, 0);
        start_seq(9, 8);
        chk("R4", "start with release 9", n_st, 1);

        // R6: hold boundary at 5
        cur_req = "R6"; clr();
        start_seq(12, 4);
        chk("R6", "start with hold 4", n_st, 0);
        start_seq(12, 5);
        chk("R6", "start with hold 5", n_st, 1);

        // R5: setup boundary at 5 (the short high pulse is also a STOP)
        cur_req = "R5"; clr();
        drv(1'b0, 1'b0, 4); drv(1'b1, 1'b0, 12); drv(1'b1, 1'b1, 4);
        drv(1'b1, 1'b0, 8); drv(1'b0, 1'b0, 12);
        chk("R5", "start with setup 4", n_st, 0);
        chk("R5", "stop with hold 4", n_sp, 0);
        // R12: STOP then START within the delay; busy must not drop
        cur_req = "R12"; clr();
        drv(1'b0, 1'b0, 4); drv(1'b1, 1'b0, 12); drv(1'b1, 1'b1, 5);
        drv(1'b1, 1'b0, 8); drv(1'b0, 1'b0, 12);
        chk("R5", "start with setup 5", n_st, 1);
        chk("R12", "stop accepted", n_sp, 1);
        chk("R12", "busy never fell", busy_fell, 0);
        chk("R12", "busy final", int'(bus_busy), 1);
        stop_seq(12);

        // R8: fixed high-speed windows
        cur_req = "R8"; clr(); fast_mode = 1'b1;
        drv(1'b1, 1'b1, 4);
        start_seq(3, 4);
        chk("R8", "fast start release 3", n_st, 0);
        start_seq(4, 2);
        chk("R8", "fast start release 4", n_st, 1);
        chk("R8", "fast busy delay", lat, 4);
        stop_seq(4);
        chk("R8", "fast stop", n_sp, 1);
        fast_mode = 1'b0;
        drv(1'b1, 1'b1, 4);

        // R10: odd value 7 acts as 8; zero acts as 2
        cur_req = "R10"; clr(); timing_val = 5'd7;
        drv(1'b1, 1'b1, 3);
        chk("R10", "cfg_err for 7", int'(cfg_err), 1);
        start_seq(8, 8);
        chk("R10", "value 7 release 8", n_st, 0);
        start_seq(9, 8);
        chk("R10", "value 7 release 9", n_st, 1);
        clr(); timing_val = 5'd0;
        stop_seq(3);
        chk("R10", "value 0 stop release 3", n_sp, 1);
        chk("R10", "cfg_err for 0", int'(cfg_err), 1);
        timing_val = 5'd8;
        drv(1'b1, 1'b1, 3);
        chk("R10", "cfg_err for 8", int'(cfg_err), 0);

        // R11: disable clears busy and blocks detection
        cur_req = "R11"; clr();
        start_seq(12, 8);
        chk("R11", "busy before disable", int'(bus_busy), 1);
        enable = 1'b0; timing_val = 5'd3;
        drv(1'b0, 1'b0, 3);
        chk("R11", "busy while disabled", int'(bus_busy), 0);
        chk("R11", "cfg_err while disabled", int'(cfg_err), 0);
        clr();
        start_seq(12, 8);
        chk("R11", "start while disabled", n_st, 0);
        chk("R11", "busy stays low", int'(bus_busy), 0);
        timing_val = 5'd8; enable = 1'b1;
        drv(1'b1, 1'b1, 10);

        cmp_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            report();
        end
    end
endmodule